// File: doc/BRIEF.md
# System Configuration Register Block

This block holds the system-level configuration words of a microcontroller and exposes them as eleven 32-bit registers on a simple single-cycle word bus. Each register bit follows one of four write policies:

- ordinary read/write;
- set-only, which sticks at 1 until reset;
- clear-only, which sticks at 0 until reset;
- a write-1-to-clear status flag that a hardware event raises.

Reserved bits read as zero, whatever is written to them.

The block also acts as the routing stage in front of an external interrupt controller. The GPIO interrupt inputs are numbered `port*16 + pin`. Each of the sixteen output lines picks one port through its own 4-bit selector. The selectors sit in the four selector registers, four to a register. The lowest-numbered line of a register uses bits 3:0, and the following lines use the next nibbles upward. Output line `n` is a combinational copy of input `sel_n*16 + n`. A selector value at or above the number of implemented ports drives its line low.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset every register reads 0, except the word at offset 0x04, which reads 0x7C000001.
- R2: Only writable bits take written data. The writable masks are 0x00000107 at 0x00, 0xFCFF0101 at 0x04, 0x0000FFFF at each of 0x08, 0x0C, 0x10 and 0x14, and 0x000000FF at 0x24. The word at 0x18 always reads 0. All other bits read 0.
- R3: Bit 0 at offset 0x04 is clear-only. Writing 0 clears it, and a later write of 1 leaves it at 0 until reset.
- R4: Bits 3:0 at offset 0x1C are set-only. A written 1 sets the bit, and a later write of 0 does not clear it before reset.
- R5: Every bit of the words at 0x20 and 0x28 is set-only. For example, writing 0xFFFFFFFF and then 0 leaves 0xFFFFFFFF.
- R6: Bit 8 at offset 0x1C is a status flag. A one-cycle pulse on `flag_set` sets it. A written 1 clears it and never sets it. A written 0 leaves it unchanged.
- R7: A read at a word offset of 0x2C or above returns 0. A write there changes no register.
- R8: Line `n` takes its selector from the register at offset `0x08 + 4*(n/4)`, bits `4*(n%4)+3 : 4*(n%4)`. Writing 0x10 at 0x08 routes input 17 to line 1.
- R9: With a selector `s` below `NPORT`, line `n` equals input `s*16+n` in the same cycle. With reset selectors, input 16 does not raise line 0, and input 15 raises only line 15.
- R10: A selector value of `NPORT` or more drives its line low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; data is stored on the rising edge |
| addr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| flag_set | input | 1 | Hardware event that sets the status flag |
| gpio_irq | input | NPORT*16 | Interrupt inputs, index port*16+pin |
| line_out | output | 16 | Routed interrupt lines |

## Verification
A write is stored at the rising edge on which `wr_en` is high, so a register read is correct from that edge onward. `rdata` is combinational in `addr`. The bench drives the address just after a falling edge and samples 1 ns later. Changes to the routing inputs and selectors appear on `line_out` in the same cycle with no register in the path, so the bench samples `line_out` 1 ns after changing `gpio_irq`. A status-flag pulse is likewise sampled after the following falling edge.

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int NPORT  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  flag_set,
  input  logic [NPORT*16-1:0]   gpio_irq,
  output logic [15:0]           line_out
);
  localparam int LINES = 16;
  localparam int NSEL  = LINES / 4;
  localparam logic [31:0] REMAP_MASK = 32'h0000_0107;
  localparam logic [31:0] CFG1_MASK  = 32'hFCFF_0101;
  localparam logic [31:0] CFG1_RST   = 32'h7C00_0001;
  localparam logic [4:0]  NPORT_W    = 5'(NPORT);

  localparam logic [ADDR_W-3:0] A_REMAP = 0;
  localparam logic [ADDR_W-3:0] A_CFG1  = 1;
  localparam logic [ADDR_W-3:0] A_SEL0  = 2;
  localparam logic [ADDR_W-3:0] A_SEL1  = 3;
  localparam logic [ADDR_W-3:0] A_SEL2  = 4;
  localparam logic [ADDR_W-3:0] A_SEL3  = 5;
  localparam logic [ADDR_W-3:0] A_STAT  = 6;
  localparam logic [ADDR_W-3:0] A_CFG2  = 7;
  localparam logic [ADDR_W-3:0] A_WP1   = 8;
  localparam logic [ADDR_W-3:0] A_KEY   = 9;
  localparam logic [ADDR_W-3:0] A_WP2   = 10;

  logic [ADDR_W-3:0] widx;
  logic [31:0]       remap_q, cfg1_q, wp1_q, wp2_q;
  logic [15:0]       sel_q [NSEL];
  logic [3:0]        cfg2_q;
  logic              flag_q;
  logic [7:0]        key_q;

  assign widx = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_q <= '0;
      cfg1_q  <= CFG1_RST;
      for (int k = 0; k < NSEL; k++) sel_q[k] <= '0;
      cfg2_q  <= '0;
      flag_q  <= 1'b0;
      wp1_q   <= '0;
      key_q   <= '0;
      wp2_q   <= '0;
    end else begin
      if (wr_en) begin
        case (widx)
          A_REMAP: remap_q <= wdata & REMAP_MASK;
          A_CFG1:  cfg1_q  <= (wdata & CFG1_MASK & ~32'h1) | {31'b0, cfg1_q[0] & wdata[0]};
          A_SEL0:  sel_q[0] <= wdata[15:0];
          A_SEL1:  sel_q[1] <= wdata[15:0];
          A_SEL2:  sel_q[2] <= wdata[15:0];
          A_SEL3:  sel_q[3] <= wdata[15:0];
          A_CFG2:  cfg2_q  <= cfg2_q | wdata[3:0];
          A_WP1:   wp1_q   <= wp1_q | wdata;
          A_KEY:   key_q   <= wdata[7:0];
          A_WP2:   wp2_q   <= wp2_q | wdata;
          default: ;
        endcase
      end
      if (flag_set)
        flag_q <= 1'b1;
      else if (wr_en && widx == A_CFG2 && wdata[8])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (widx)
      A_REMAP: rdata = remap_q;
      A_CFG1:  rdata = cfg1_q;
      A_SEL0:  rdata = {16'b0, sel_q[0]};
      A_SEL1:  rdata = {16'b0, sel_q[1]};
      A_SEL2:  rdata = {16'b0, sel_q[2]};
      A_SEL3:  rdata = {16'b0, sel_q[3]};
      A_STAT:  rdata = '0;
      A_CFG2:  rdata = {23'b0, flag_q, 4'b0, cfg2_q};
      A_WP1:   rdata = wp1_q;
      A_KEY:   rdata = {24'b0, key_q};
      A_WP2:   rdata = wp2_q;
      default: rdata = '0;
    endcase
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [15:0] col;
    logic [3:0]  sel;
    assign sel = sel_q[n/4][(n%4)*4 +: 4];
    for (genvar p = 0; p < 16; p++) begin : g_port
      if (p < NPORT) begin : g_on
        assign col[p] = gpio_irq[p*16+n];
      end else begin : g_off
        assign col[p] = 1'b0;
      end
    end
    assign line_out[n] = col[sel];

    p_sel_range_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, sel} >= NPORT_W) |-> !line_out[n]);
  end

  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg1_q[0] |=> !cfg1_q[0]);
  p_sticky_cfg2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cfg2_q & $past(cfg2_q)) == $past(cfg2_q)));
  p_sticky_wp1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wp1_q & $past(wp1_q)) == $past(wp1_q)));
  p_sticky_wp2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wp2_q & $past(wp2_q)) == $past(wp2_q)));
  p_flag_no_write_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !flag_set) |=> !flag_q);
  p_flag_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == A_CFG2 && wdata[8] && !flag_set) |=> !flag_q);
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (widx > A_WP2) |-> (rdata == 32'h0));
endmodule

// File: tb/test_sys_cfg_regs.sv
module test_sys_cfg_regs;
  localparam int AW = 8;
  localparam int NP = 5;
  localparam int NREG = 14;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, flag_set = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP*16-1:0] gpio_irq = '0;
  logic [15:0] line_out;

  int nvec = 0, nfail = 0;
  logic [31:0] m [NREG];

  always #5 clk = ~clk;

  sys_cfg_regs #(.ADDR_W(AW), .NPORT(NP)) i_sys_cfg_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .flag_set(flag_set), .gpio_irq(gpio_irq), .line_out(line_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(int i);
    if (i == 1) return "R3";
    if (i == 7) return "R4";
    if (i == 8 || i == 10) return "R5";
    if (i >= 11) return "R7";
    return "R2";
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) m[i] = 32'h0;
    m[1] = 32'h7C00_0001;
  endtask

  task automatic wr(int i, logic [31:0] d);
    @(negedge clk);
    addr = AW'(i*4); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (i)
      0: m[0] = d & 32'h107;
      1: m[1] = (d & 32'hFCFF_0100) | {31'b0, m[1][0] & d[0]};
      2, 3, 4, 5: m[i] = d & 32'hFFFF;
      7: m[7] = {23'b0, m[7][8] & ~d[8], 4'b0, m[7][3:0] | d[3:0]};
      8, 10: m[i] = m[i] | d;
      9: m[9] = d & 32'hFF;
      default: ;
    endcase
  endtask

  task automatic rd(int i, string req);
    addr = AW'(i*4);
    #1;
    chk(req, rdata, m[i]);
  endtask

  function automatic logic [15:0] exp_lines();
    logic [15:0] e;
    for (int n = 0; n < 16; n++) begin
      int s;
      s = int'(m[2 + n/4][(n%4)*4 +: 4]);
      e[n] = (s < NP) ? gpio_irq[s*16+n] : 1'b0;
    end
    return e;
  endfunction

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h1234_5678; pats[5] = 32'h0;
    do_reset();
    @(negedge clk);
    for (int i = 0; i < NREG; i++) rd(i, (i >= 11) ? "R7" : "R1");
    chk("R1", {16'b0, line_out}, 32'h0);

    for (int p = 0; p < 6; p++)
      for (int i = 0; i < NREG; i++) begin
        wr(i, pats[p]);
        for (int j = 0; j < NREG; j++) rd(j, req_of(i));
      end

    do_reset();
    wr(7, 32'h100); rd(7, "R6");
    @(negedge clk); flag_set = 1'b1; @(negedge clk); flag_set = 1'b0;
    m[7][8] = 1'b1; rd(7, "R6");
    wr(7, 32'h0); rd(7, "R6");
    wr(7, 32'h105); rd(7, "R6");
    chk("R6", rdata, 32'h5);
    wr(7, 32'h0); rd(7, "R4");

    do_reset();
    @(negedge clk);
    gpio_irq = '0; gpio_irq[16] = 1'b1; #1;
    chk("R9", {16'b0, line_out}, 32'h0);
    gpio_irq = '0; gpio_irq[15] = 1'b1; #1;
    chk("R9", {16'b0, line_out}, 32'h8000);
    gpio_irq = '0;
    wr(2, 32'h10);
    gpio_irq[17] = 1'b1; #1;
    chk("R8", {16'b0, line_out}, 32'h0002);
    gpio_irq = '0;

    for (int n = 0; n < 16; n++)
      for (int s = 0; s < 16; s++) begin
        logic [31:0] w;
        string tag;
        w = m[2 + n/4];
        w[(n%4)*4 +: 4] = 4'(s);
        wr(2 + n/4, w);
        tag = (s < NP) ? "R9" : "R10";
        for (int k = 0; k < 4; k++) begin
          gpio_irq = '0;
          case (k)
            0: if (s < NP) gpio_irq[s*16+n] = 1'b1;
            1: gpio_irq[((s+1)%NP)*16+n] = 1'b1;
            2: gpio_irq = '1;
            default: for (int b = 0; b < NP*16; b++) gpio_irq[b] = ((b*7+n+s) % 3) == 0;
          endcase
          #1;
          chk(tag, {16'b0, line_out}, {16'b0, exp_lines()});
        end
        gpio_irq = '0;
      end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule